// File: doc/BRIEF.md
# Periodic Timebase Interrupt Generator

This block divides a selectable timebase tick down to a periodic interrupt. A 15-bit prescaler counter advances once for each qualifying tick. A 3-bit code picks one of eight counter bits, and the flag is set each time that bit goes from 0 to 1. Because the event is taken on a bit rising, the first flag after enabling arrives after half the chosen period. After that the flag comes once per full period. Software writes a control word, reads back the control fields and the flag, and clears the flag by writing 1 to an acknowledge bit. The interrupt request is the flag gated by an enable bit.

The timebase is one of two tick enables on the block clock. When `ext_sel` is 1 the block uses `ext_tick`, otherwise it uses `int_tick`. During stop mode the counter freezes unless the keep-alive input is 1. With keep-alive set, the interrupt can serve as a periodic wakeup.

A small state machine governs the counter. It has three states:
- TB_OFF: the counter is held at zero.
- TB_RUN: the counter advances on each tick.
- TB_FROZEN: the counter holds its value.

The transitions are:
- OFF→RUN on a write with the run bit set.
- RUN→OFF and FROZEN→OFF on a write with the run bit clear.
- RUN→FROZEN when stop is active without keep-alive.
- FROZEN→RUN when that condition ends.

State changes take effect one clock after the cause.

Top module: `tbase_pit`

## Requirements
- R1: Control word layout is: bit0 run, bits3:1 tap code, bit4 interrupt enable, bit5 acknowledge. Read data is {flag, 0, 0 (acknowledge reads 0), ie, tap, run}. After reset the read data is 0x00, `irq` is 0 and the counter is zero.
- R2: While the run bit is 0 the counter is held at zero. Enabling again always restarts counting from zero.
- R3: In TB_RUN the counter increments by one on each cycle where the selected tick is 1.
- R4: Tap codes 0 to 7 select divide ratios 8, 16, 128, 256, 1024, 2048, 4096 and 32768 in that order. The flag is set when counter bit log2(N)-1 goes from 0 to 1.
- R5: The first flag after enabling occurs on the N/2-th tick. Each later flag occurs exactly N ticks after the previous one.
- R6: `irq` is 1 exactly when both the flag and the interrupt enable are 1.
- R7: A write with bit5 = 1 clears the flag. A write with bit5 = 0 leaves the flag unchanged.
- R8: If a flag event and an acknowledge write fall in the same cycle, the flag ends up set.
- R9: A write that changes the tap code does not reset the counter. The next flag comes from the new bit's next 0-to-1 transition.
- R10: With `ext_sel` = 1 only `ext_tick` advances the counter. With `ext_sel` = 0 only `int_tick` advances it.
- R11: While `stop_mode` = 1 and `stop_keep` = 0 the counter freezes. With `stop_keep` = 1 it keeps running and still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | Selects the external tick as the timebase |
| ext_tick | input | 1 | External timebase tick enable |
| int_tick | input | 1 | Internal timebase tick enable |
| stop_mode | input | 1 | System is in stop mode |
| stop_keep | input | 1 | Keep the timebase running in stop mode |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 6 | Control word (layout in R1) |
| reg_rdata | output | 8 | Readback of controls and flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acknowledge write that lands in exactly the cycle where the selected counter bit rises. To reach it, the bench first counts ticks from a freshly cleared counter until it is one tick short of the half period. It then drives the tick and the acknowledge write on the same edge. A second hard case is a tap change at a known counter value in which the old bit is already high. This case shows that the event comes from the new bit's rising edge rather than from a counter restart.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    typedef enum logic [1:0] {
        TB_OFF    = 2'd0,
        TB_RUN    = 2'd1,
        TB_FROZEN = 2'd2
    } tb_state_e;

    localparam int TB_CODES = 8;
    localparam int TB_SEL_W = $clog2(TB_CODES);
    localparam int TB_CNT_W = 15;

    // counter bit whose rising edge marks an event for each tap code
    function automatic int tap_bit(input int code);
        case (code)
            0:       return 2;
            1:       return 3;
            2:       return 6;
            3:       return 7;
            4:       return 9;
            5:       return 10;
            6:       return 11;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
    import tbase_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic                wr_run,
    input  logic [TB_SEL_W-1:0] wr_tap,
    input  logic                wr_ie,
    input  logic                stop_mode,
    input  logic                stop_keep,
    output logic                run_q,
    output logic [TB_SEL_W-1:0] tap_q,
    output logic                ie_q,
    output logic                cnt_clr,
    output logic                cnt_en
);

    tb_state_e state_q, state_d;
    logic      freeze_req;

    assign freeze_req = stop_mode && !stop_keep;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TB_OFF:    if (wr && wr_run)  state_d = TB_RUN;
            TB_RUN:    if (wr && !wr_run) state_d = TB_OFF;
                       else if (freeze_req) state_d = TB_FROZEN;
            TB_FROZEN: if (wr && !wr_run) state_d = TB_OFF;
                       else if (!freeze_req) state_d = TB_RUN;
            default:   state_d = TB_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TB_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            tap_q <= '0;
            ie_q  <= 1'b0;
        end else if (wr) begin
            run_q <= wr_run;
            tap_q <= wr_tap;
            ie_q  <= wr_ie;
        end
    end

    always_comb begin
        cnt_clr = (state_q == TB_OFF);
        cnt_en  = (state_q == TB_RUN);
    end

    // R11: a frozen machine that is neither released nor disabled stays frozen
    p_frozen_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TB_FROZEN && freeze_req && !wr) |=> (state_q == TB_FROZEN));

    // R2: a write clearing the run bit always leads to the counter-clear state
    p_disable_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wr_run) |=> cnt_clr);

endmodule

// File: rtl/tbase_count.sv
module tbase_count
    import tbase_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                en,
    input  logic                tick,
    input  logic [TB_SEL_W-1:0] tap_sel,
    output logic                evt
);

    localparam int CW = TB_CNT_W;

    logic [CW-1:0]       cnt_q, cnt_nxt;
    logic [TB_CODES-1:0] rise;
    logic                step;

    assign step    = en && tick;
    assign cnt_nxt = cnt_q + 1'b1;

    for (genvar g = 0; g < TB_CODES; g++) begin : g_tap
        localparam int B = tap_bit(g);
        assign rise[g] = cnt_nxt[B] & ~cnt_q[B];
    end

    assign evt = step && rise[tap_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_nxt;
        end
    end

    // R2: counter is zero after any cycle spent in the off state
    p_off_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R3: one increment per qualifying tick
    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

    // R11: without a qualifying tick the counter holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> $stable(cnt_q));

endmodule

// File: rtl/tbase_flag.sv
module tbase_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic ack_wr,
    input  logic ie,
    output logic flag_q,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (evt) begin
            flag_q <= 1'b1;
        end else if (ack_wr) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && ie;

    // R8: an event always leaves the flag set, acknowledge or not
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);

    // R7: acknowledge without a coincident event clears the flag
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !evt) |=> !flag_q);

endmodule

// File: rtl/tbase_pit.sv
module tbase_pit
    import tbase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_sel,
    input  logic       ext_tick,
    input  logic       int_tick,
    input  logic       stop_mode,
    input  logic       stop_keep,
    input  logic       reg_wr,
    input  logic [5:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);

    logic                run_q, ie_q, cnt_clr, cnt_en, evt, flag_q, tb_tick;
    logic [TB_SEL_W-1:0] tap_q;

    assign tb_tick = ext_sel ? ext_tick : int_tick;

    tbase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wr_run    (reg_wdata[0]),
        .wr_tap    (reg_wdata[3:1]),
        .wr_ie     (reg_wdata[4]),
        .stop_mode (stop_mode),
        .stop_keep (stop_keep),
        .run_q     (run_q),
        .tap_q     (tap_q),
        .ie_q      (ie_q),
        .cnt_clr   (cnt_clr),
        .cnt_en    (cnt_en)
    );

    tbase_count u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .en      (cnt_en),
        .tick    (tb_tick),
        .tap_sel (tap_q),
        .evt     (evt)
    );

    tbase_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (evt),
        .ack_wr (reg_wr && reg_wdata[5]),
        .ie     (ie_q),
        .flag_q (flag_q),
        .irq    (irq)
    );

    assign reg_rdata = {flag_q, 2'b00, ie_q, tap_q, run_q};

    // R6: a request never appears while interrupts are disabled
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> reg_rdata[4]);

    // R4: flag events only occur while the block is running
    p_evt_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> reg_rdata[0] || $past(reg_rdata[0]));

endmodule

// File: tb/sim_tbase_pit.sv
module sim_tbase_pit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_sel = 1'b0, ext_tick = 1'b0, int_tick = 1'b0;
    logic       stop_mode = 1'b0, stop_keep = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tbase_pit u0 (
        .clk(clk), .rst_n(rst_n), .ext_sel(ext_sel), .ext_tick(ext_tick),
        .int_tick(int_tick), .stop_mode(stop_mode), .stop_keep(stop_keep),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic iticks(input int n);
        for (int i = 0; i < n; i++) begin
            int_tick = 1'b1;
            @(negedge clk);
        end
        int_tick = 1'b0;
    endtask

    task automatic eticks(input int n);
        for (int i = 0; i < n; i++) begin
            ext_tick = 1'b1;
            @(negedge clk);
        end
        ext_tick = 1'b0;
    endtask

    function automatic logic [5:0] cw(input logic ack, input logic ie,
                                      input logic [2:0] tap, input logic run);
        return {ack, ie, tap, run};
    endfunction

    // clear counter and flag, then enable with the given tap and ie
    task automatic restart(input logic [2:0] tap, input logic ie);
        wr(cw(1'b1, 1'b0, 3'd0, 1'b0));
        wr(cw(1'b0, ie, tap, 1'b1));
    endtask

    task automatic t_reset;
        check("R1 reset rdata", reg_rdata, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_div8_period;
        restart(3'd0, 1'b0);
        check("R1 readback", reg_rdata, 8'h01);
        iticks(3);
        check("R5 before half", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R5 first at N/2", {7'b0, reg_rdata[7]}, 8'h01);
        wr(cw(1'b1, 1'b0, 3'd0, 1'b1));
        iticks(7);
        check("R5 before full", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R5 full period", {7'b0, reg_rdata[7]}, 8'h01);
    endtask

    task automatic t_irq_ack;
        check("R6 ie off", {7'b0, irq}, 8'h00);
        wr(cw(1'b0, 1'b1, 3'd0, 1'b1));
        check("R7 ack0 keeps flag", {7'b0, reg_rdata[7]}, 8'h01);
        check("R6 irq on", {7'b0, irq}, 8'h01);
        wr(cw(1'b1, 1'b1, 3'd0, 1'b1));
        check("R7 ack clears", {7'b0, reg_rdata[7]}, 8'h00);
        check("R6 irq off after ack", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tap_table;
        restart(3'd2, 1'b0);
        iticks(63);
        check("R4 tap2 before", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R4 tap2 at 64", {7'b0, reg_rdata[7]}, 8'h01);
        wr(cw(1'b1, 1'b0, 3'd2, 1'b1));
        iticks(127);
        check("R5 tap2 before 128", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R5 tap2 period 128", {7'b0, reg_rdata[7]}, 8'h01);
        restart(3'd7, 1'b0);
        iticks(16383);
        check("R4 tap7 before", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R4 tap7 at 16384", {7'b0, reg_rdata[7]}, 8'h01);
    endtask

    task automatic t_disable_restart;
        restart(3'd0, 1'b0);
        iticks(3);
        restart(3'd0, 1'b0);
        iticks(3);
        check("R2 restart from zero", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R2 restart event", {7'b0, reg_rdata[7]}, 8'h01);
    endtask

    task automatic t_set_wins;
        restart(3'd0, 1'b0);
        iticks(3);
        int_tick = 1'b1; reg_wr = 1'b1; reg_wdata = cw(1'b1, 1'b0, 3'd0, 1'b1);
        @(negedge clk);
        int_tick = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R8 set beats ack", {7'b0, reg_rdata[7]}, 8'h01);
    endtask

    task automatic t_tap_change;
        restart(3'd0, 1'b0);
        iticks(5);
        check("R9 tap0 fired", {7'b0, reg_rdata[7]}, 8'h01);
        wr(cw(1'b1, 1'b0, 3'd1, 1'b1));
        iticks(2);
        check("R9 no restart event", {7'b0, reg_rdata[7]}, 8'h00);
        iticks(1);
        check("R9 new bit rises at 8", {7'b0, reg_rdata[7]}, 8'h01);
    endtask

    task automatic t_source;
        restart(3'd0, 1'b0);
        ext_sel = 1'b1;
        iticks(10);
        check("R10 int ignored", {7'b0, reg_rdata[7]}, 8'h00);
        eticks(4);
        check("R10 ext counts", {7'b0, reg_rdata[7]}, 8'h01);
        ext_sel = 1'b0;
        restart(3'd0, 1'b0);
        eticks(10);
        check("R10 ext ignored", {7'b0, reg_rdata[7]}, 8'h00);
    endtask

    task automatic t_stop;
        restart(3'd0, 1'b0);
        stop_mode = 1'b1;
        @(negedge clk);
        iticks(10);
        check("R11 frozen", {7'b0, reg_rdata[7]}, 8'h00);
        stop_mode = 1'b0;
        @(negedge clk);
        iticks(4);
        check("R11 resume", {7'b0, reg_rdata[7]}, 8'h01);
        restart(3'd0, 1'b0);
        stop_mode = 1'b1; stop_keep = 1'b1;
        @(negedge clk);
        iticks(4);
        check("R11 keep alive", {7'b0, reg_rdata[7]}, 8'h01);
        stop_mode = 1'b0; stop_keep = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_div8_period();
        t_irq_ack();
        t_tap_table();
        t_disable_restart();
        t_set_wins();
        t_tap_change();
        t_source();
        t_stop();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule